// File: doc/BRIEF.md
# PCI Interrupt Steering Router

This block takes eight shared PCI interrupt request levels (PIRQ A through H) and drives two interrupt domains at once. On the legacy side there are sixteen lines. Each PIRQ can be steered onto any one of them through its own routing byte, and several PIRQs steered to the same line are wired-OR together. On the dedicated side there are eight more lines, 16 to 23. Each PIRQ always drives its own line there, whatever its routing byte says. A single ACPI system control interrupt (SCI) level is merged onto one line, which a select field picks.

Routing state is loaded through a byte-wide register write port. When software moves the SCI to a different line while the SCI is asserted, the block drops the SCI from every line for one cycle before it raises the SCI on the new line. A combinational lookup also reports which PIRQ a given slot and device pin is wired to. All interrupt outputs come from a single register stage.

Top module: `irq_steer_router`

## Requirements
- R1: While reset is asserted, and after it is released, every output is low and every routing byte has its disable bit (bit 7) set, so no PIRQ reaches a legacy line until that PIRQ is programmed.
- R2: A write to address p (0 to 7) loads the routing byte for PIRQ p. Addresses 0 to 3 hold PIRQ A to D and 4 to 7 hold PIRQ E to H. Bits 3:0 give the legacy line number and bit 7 is the disable bit.
- R3: Each legacy line 0 to 15 is the OR of every enabled PIRQ routed to that line, so two PIRQs that share a line both drive it.
- R4: A PIRQ whose routing byte has bit 7 set drives no legacy line.
- R5: PIRQ n always drives output 16+n, whatever its routing byte holds.
- R6: Bits 6:4 of a write to address 8 hold the SCI select. The codes map as 0 to line 9, 1 to line 10, 2 to line 11, 4 to line 20 and 5 to line 21. The SCI level is ORed onto the selected line.
- R7: The select codes 3, 6 and 7 are reserved, and with any of them the SCI drives no output.
- R8: If the select is written with a different code while the SCI is high, the SCI is removed from all lines for exactly one output cycle and then appears on the new line. If the SCI is low, the new route takes effect with no gap.
- R9: The slot lookup returns PIRQ ((slot + pin) mod 4) + 4 for pin INTA to INTD (coded 0 to 3), so PIRQ A to D are never returned.
- R10: Slot 30 is fixed so that INTA to INTD map to PIRQ E to H in order.
- R11: A change on a PIRQ or SCI input, or a routing write, shows at the outputs after the next rising clock edge and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Write address (0 to 7 routing bytes, 8 SCI select) |
| wrData | input | 8 | Write data |
| pirqLvl | input | 8 | PIRQ A to H levels, bit 0 = A |
| sciLvl | input | 1 | SCI level |
| mapSlot | input | 5 | Slot number for the pin lookup |
| mapPin | input | 2 | Device pin for the lookup, 0 = INTA |
| mapPirq | output | 3 | PIRQ index that the slot and pin map to |
| irqOut | output | 24 | Interrupt levels, 0 to 15 legacy, 16 to 23 dedicated |

## Verification
The bench steers two PIRQs onto one legacy line and releases them one at a time. A design that priority-muxed the sources instead of ORing them would drop that line while one source was still high. A disabled PIRQ is held high to show that it reaches only its dedicated line, which would catch an inverted or ignored disable bit. The SCI is moved between lines while it is high, onto a reserved code, and while it is low. A design without the one-cycle gap would show the old and new lines switching in the same cycle, and one that decoded reserved codes would raise a stray line. All 128 slot and pin pairs are swept in the lookup, which exposes a missing slot 30 override or an offset into PIRQ A to D.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
  localparam int NUM_PIRQ   = 8;
  localparam int NUM_LEGACY = 16;
  localparam int NUM_OUT    = NUM_LEGACY + NUM_PIRQ;
  localparam int LINE_W     = $clog2(NUM_LEGACY);
  localparam int OUT_IDX_W  = $clog2(NUM_OUT);
  localparam int PIRQ_IDX_W = $clog2(NUM_PIRQ);
  localparam int ADDR_W     = 4;
  localparam int DATA_W     = 8;
  localparam int DIS_BIT    = 7;
  localparam int SEL_W      = 3;
  localparam int SEL_LSB    = 4;
  localparam int SEL_ADDR   = NUM_PIRQ;
  localparam int SLOT_W     = 5;
  localparam int PIN_W      = 2;

  typedef struct packed {
    logic              dis;
    logic [LINE_W-1:0] line;
  } route_t;

  typedef struct packed {
    logic                 mute;
    logic                 on;
    logic [OUT_IDX_W-1:0] line;
  } sci_strb_t;

  // returns {valid, line}
  function automatic logic [OUT_IDX_W:0] sciDecode(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd0:    return {1'b1, OUT_IDX_W'(9)};
      3'd1:    return {1'b1, OUT_IDX_W'(10)};
      3'd2:    return {1'b1, OUT_IDX_W'(11)};
      3'd4:    return {1'b1, OUT_IDX_W'(20)};
      3'd5:    return {1'b1, OUT_IDX_W'(21)};
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/irq_steer_ctrl.sv
module irq_steer_ctrl
  import irq_steer_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wrEn,
  input  logic [ADDR_W-1:0]          wrAddr,
  input  logic [DATA_W-1:0]          wrData,
  input  logic                       sciLvl,
  output route_t [NUM_PIRQ-1:0]      routes,
  output sci_strb_t                  sciStrb
);
  localparam route_t ROUTE_RST = '{dis: 1'b1, line: '0};

  route_t [NUM_PIRQ-1:0] routeQ;
  logic [SEL_W-1:0]      selQ;
  logic                  muteQ;
  logic                  selWr;
  logic                  selMove;
  logic [SEL_W-1:0]      selNew;
  logic                  decValid;
  logic [OUT_IDX_W-1:0]  decLine;

  assign selNew  = wrData[SEL_LSB +: SEL_W];
  assign selWr   = wrEn && (wrAddr == ADDR_W'(SEL_ADDR));
  assign selMove = selWr && (selNew != selQ) && sciLvl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      routeQ <= {NUM_PIRQ{ROUTE_RST}};
      selQ   <= '0;
      muteQ  <= 1'b0;
    end else begin
      muteQ <= selMove;
      if (selWr) selQ <= selNew;
      for (int p = 0; p < NUM_PIRQ; p++) begin
        if (wrEn && (wrAddr == ADDR_W'(p))) begin
          routeQ[p] <= '{dis: wrData[DIS_BIT], line: wrData[LINE_W-1:0]};
        end
      end
    end
  end

  assign {decValid, decLine} = sciDecode(selQ);
  assign routes  = routeQ;
  assign sciStrb = '{mute: muteQ, on: decValid && !muteQ, line: decLine};

  // R2
  route_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrEn |=> $stable(routeQ));

  // R7
  sci_line_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sciStrb.on |-> (sciStrb.line inside {5'd9, 5'd10, 5'd11, 5'd20, 5'd21}));
endmodule

// File: rtl/irq_steer_dp.sv
module irq_steer_dp
  import irq_steer_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  route_t [NUM_PIRQ-1:0] routes,
  input  sci_strb_t             sciStrb,
  input  logic [NUM_PIRQ-1:0]   pirqLvl,
  input  logic                  sciLvl,
  output logic [NUM_OUT-1:0]    irqOut
);
  logic [NUM_OUT-1:0] sciVec;
  logic [NUM_OUT-1:0] nxt;

  always_comb begin
    sciVec = '0;
    if (sciStrb.on && sciLvl) sciVec[sciStrb.line] = 1'b1;
  end

  for (genvar l = 0; l < NUM_LEGACY; l++) begin : g_leg
    logic [NUM_PIRQ-1:0] hit;
    for (genvar p = 0; p < NUM_PIRQ; p++) begin : g_src
      assign hit[p] = pirqLvl[p] && !routes[p].dis && (routes[p].line == LINE_W'(l));
    end
    assign nxt[l] = (|hit) | sciVec[l];
  end

  for (genvar n = 0; n < NUM_PIRQ; n++) begin : g_ded
    assign nxt[NUM_LEGACY+n] = pirqLvl[n] | sciVec[NUM_LEGACY+n];

    // R5
    ded_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pirqLvl[n] |=> irqOut[NUM_LEGACY+n]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irqOut <= '0;
    else        irqOut <= nxt;
  end

  // R1
  quiet_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pirqLvl == '0 && !sciLvl) |=> (irqOut == '0));

  // R8
  sci_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sciStrb.mute && pirqLvl == '0) |=> (irqOut == '0));
endmodule

// File: rtl/irq_slot_map.sv
module irq_slot_map
  import irq_steer_pkg::*;
#(
  parameter int FIXED_SLOT = 30
) (
  input  logic [SLOT_W-1:0]     slot,
  input  logic [PIN_W-1:0]      pin,
  output logic [PIRQ_IDX_W-1:0] pirq
);
  localparam int HALF = NUM_PIRQ / 2;

  logic [PIN_W-1:0] rotated;

  always_comb begin
    rotated = slot[PIN_W-1:0] + pin;
    if (slot == SLOT_W'(FIXED_SLOT)) pirq = PIRQ_IDX_W'(HALF) + PIRQ_IDX_W'(pin);
    else                             pirq = PIRQ_IDX_W'(HALF) + PIRQ_IDX_W'(rotated);
    // R9
    map_upper_chk: assert (pirq >= PIRQ_IDX_W'(HALF));
  end
endmodule

// File: rtl/irq_steer_router.sv
module irq_steer_router
  import irq_steer_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [NUM_PIRQ-1:0]   pirqLvl,
  input  logic                  sciLvl,
  input  logic [SLOT_W-1:0]     mapSlot,
  input  logic [PIN_W-1:0]      mapPin,
  output logic [PIRQ_IDX_W-1:0] mapPirq,
  output logic [NUM_OUT-1:0]    irqOut
);
  route_t [NUM_PIRQ-1:0] routes;
  sci_strb_t             sciStrb;

  irq_steer_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .sciLvl  (sciLvl),
    .routes  (routes),
    .sciStrb (sciStrb)
  );

  irq_steer_dp u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .routes  (routes),
    .sciStrb (sciStrb),
    .pirqLvl (pirqLvl),
    .sciLvl  (sciLvl),
    .irqOut  (irqOut)
  );

  irq_slot_map #(.FIXED_SLOT(30)) u_map (
    .slot (mapSlot),
    .pin  (mapPin),
    .pirq (mapPirq)
  );
endmodule

// File: tb/tb_irq_steer_router.sv
module tb_irq_steer_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic [7:0]  pirqLvl = '0;
  logic        sciLvl = 1'b0;
  logic [4:0]  mapSlot = '0;
  logic [1:0]  mapPin = '0;
  logic [2:0]  mapPirq;
  logic [23:0] irqOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state
  logic [7:0] mRoute [8];
  logic [2:0] mSel;
  logic       mMute;

  logic [23:0] expQ [$];
  string       tagQ [$];

  always #10 clk = ~clk;

  irq_steer_router dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pirqLvl(pirqLvl), .sciLvl(sciLvl), .mapSlot(mapSlot), .mapPin(mapPin),
    .mapPirq(mapPirq), .irqOut(irqOut)
  );

  task automatic check(string req, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] expOut(logic [7:0] pq, logic s);
    logic [23:0] e = '0;
    for (int p = 0; p < 8; p++)
      if (pq[p] && !mRoute[p][7]) e[mRoute[p][3:0]] = 1'b1;
    for (int n = 0; n < 8; n++)
      if (pq[n]) e[16+n] = 1'b1;
    if (s && !mMute) begin
      case (mSel)
        3'd0: e[9]  = 1'b1;
        3'd1: e[10] = 1'b1;
        3'd2: e[11] = 1'b1;
        3'd4: e[20] = 1'b1;
        3'd5: e[21] = 1'b1;
        default: ;
      endcase
    end
    return e;
  endfunction

  // driver: one clock cycle of stimulus, expected result pushed to scoreboard
  task automatic cycle(logic [7:0] pq, logic s, logic we, logic [3:0] a,
                       logic [7:0] d, string tag);
    logic newMute;
    @(negedge clk);
    pirqLvl = pq; sciLvl = s; wrEn = we; wrAddr = a; wrData = d;
    expQ.push_back(expOut(pq, s));
    tagQ.push_back(tag);
    newMute = we && (a == 4'd8) && (d[6:4] != mSel) && s;
    if (we && a == 4'd8) mSel = d[6:4];
    if (we && a < 4'd8) mRoute[a[2:0]] = d;
    mMute = newMute;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        logic [23:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, irqOut, e);
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < 8; i++) mRoute[i] = 8'h80;
    mSel = 3'd0;
    mMute = 1'b0;
    pirqLvl = 8'hFF;
    repeat (3) @(negedge clk);
    check("R1 outputs low in reset", irqOut, 24'h0);
    rst_n = 1'b1;

    // R1 R4 R5: all PIRQs high, none routed to legacy after reset
    cycle(8'hFF, 0, 0, 0, 0, "R1 reset routing disabled");
    cycle(8'hFF, 0, 0, 0, 0, "R5 dedicated follow");
    // R2 program: A->5, B->5, E->10, H disabled with line 12
    cycle(8'h00, 0, 1, 4'd0, 8'h05, "R2 write A");
    cycle(8'h00, 0, 1, 4'd1, 8'h05, "R2 write B");
    cycle(8'h00, 0, 1, 4'd4, 8'h0A, "R2 write E");
    cycle(8'h00, 0, 1, 4'd7, 8'h8C, "R2 write H");
    cycle(8'h01, 0, 0, 0, 0, "R2 PIRQ A on line 5");
    cycle(8'h02, 0, 0, 0, 0, "R3 PIRQ B on line 5");
    cycle(8'h03, 0, 0, 0, 0, "R3 A and B share line 5");
    cycle(8'h02, 0, 0, 0, 0, "R3 line 5 held by B");
    cycle(8'h10, 0, 0, 0, 0, "R2 PIRQ E on line 10");
    cycle(8'h80, 0, 0, 0, 0, "R4 PIRQ H disabled");
    cycle(8'h8C, 0, 0, 0, 0, "R5 dedicated only");
    // SCI on default select (line 9)
    cycle(8'h00, 1, 0, 0, 0, "R6 SCI on line 9");
    cycle(8'h00, 1, 1, 4'd8, 8'h40, "R8 move to 20 write");
    cycle(8'h00, 1, 0, 0, 0, "R8 gap cycle");
    cycle(8'h00, 1, 0, 0, 0, "R8 SCI on line 20");
    cycle(8'h00, 1, 1, 4'd8, 8'h30, "R7 move to reserved");
    cycle(8'h00, 1, 0, 0, 0, "R7 gap");
    cycle(8'h00, 1, 0, 0, 0, "R7 reserved drives nothing");
    cycle(8'h00, 1, 1, 4'd8, 8'h50, "R6 select 21 write");
    cycle(8'h00, 1, 0, 0, 0, "R8 gap before 21");
    cycle(8'h00, 1, 0, 0, 0, "R6 SCI on line 21");
    cycle(8'h00, 1, 1, 4'd8, 8'h50, "R8 same code no gap");
    cycle(8'h00, 1, 0, 0, 0, "R8 same code keeps 21");
    cycle(8'h00, 0, 1, 4'd8, 8'h10, "R8 move while low");
    cycle(8'h00, 1, 0, 0, 0, "R8 no gap while low, line 10");
    cycle(8'h10, 1, 0, 0, 0, "R3 SCI and PIRQ E share 10");
    cycle(8'h10, 0, 0, 0, 0, "R3 line 10 held by E");
    cycle(8'h00, 1, 1, 4'd8, 8'h20, "R6 select 11 write");
    cycle(8'h00, 1, 0, 0, 0, "R8 gap before 11");
    cycle(8'h00, 1, 0, 0, 0, "R6 SCI on line 11");
    cycle(8'h00, 0, 1, 4'd8, 8'h70, "R7 code 7 write");
    cycle(8'h00, 1, 0, 0, 0, "R7 code 7 drives nothing");
    cycle(8'h00, 0, 0, 0, 0, "R6 idle");
    repeat (3) @(negedge clk);

    // R11: input change not visible before the clock edge
    pirqLvl = 8'h04;
    #2;
    check("R11 no change before edge", irqOut, 24'h0);
    @(posedge clk); #1;
    check("R11 change after edge", irqOut, 24'h040000);

    // R9 R10: pin lookup sweep
    for (int s = 0; s < 32; s++) begin
      for (int x = 0; x < 4; x++) begin
        @(negedge clk);
        mapSlot = 5'(s);
        mapPin = 2'(x);
        #1;
        if (s == 30) check("R10 slot 30 fixed", 24'(mapPirq), 24'(4 + x));
        else         check("R9 slot rotation", 24'(mapPirq), 24'(((s + x) % 4) + 4));
      end
    end
    summary();
  end
endmodule